// File: doc/BRIEF.md
# Flash Byte-Access Register Controller

This block sits between a processor's I/O register bus and a byte-wide flash array. Software loads a location into three address registers (page, row, column) and then reads or writes a single data register. Each data access moves the stored location forward by one byte, so a run of bytes can be streamed through the data register without reloading the address. This register path reaches every page of the array, including the information page that memory-mapped reads cannot reach.

Reads wait for a number of extra cycles set in the control register before they return the byte. Writes start a timed program pulse. The bus is stalled with a wait signal for the whole pulse. The pulse length comes from a register and is clamped to a legal window. Before any pulse starts, two integrity rules are checked. A byte may not be programmed twice between erases, and the summed pulse time applied to one 256-byte row may not go over a budget. A refused write sets a sticky error flag and applies no pulse. An erase input clears the bookkeeping and the flag. An enable bit in the control register lets software turn off all array access.

Top module: `flash_io_ctrl`

## Requirements
- R1: After reset, io_wait, io_ack, fl_prog and err are low. The control register reads 0, the address registers read 0, and the pulse-length register reads PROG_MIN.
- R2: Register select codes are 0 control, 1 page, 2 row, 3 column, 4 data, 5 pulse length. A non-data register access is acknowledged in the cycle after its strobe, with io_wait never high. Page, row, column and pulse length read back what was written, zero-extended.
- R3: The control register holds enable in bit 0, read wait states in bits 3:1, and the sticky error in bit 7. An enabled data read with n wait states holds io_wait high for n+1 cycles. io_ack comes n+2 cycles after the strobe and carries the byte at the current address.
- R4: Every data access advances the address by one. When the column passes 255 it goes to 0 and the row increments. When the row passes its maximum it goes to 0 and the page increments.
- R5: An accepted data write holds fl_prog and io_wait high for exactly the effective pulse length L. fl_addr and fl_wdata stay steady during the pulse. io_ack comes L+1 cycles after the strobe.
- R6: The effective pulse length is the pulse-length register clamped to the range [PROG_MIN, PROG_MAX]. The register itself reads back unclamped.
- R7: A write to a byte that has already been programmed since the last erase gets no pulse. It sets err, is acknowledged in the next cycle, and still advances the address.
- R8: A write is refused in the same way as R7 when the row's accumulated pulse time plus L would exceed ROW_BUDGET.
- R9: A one-cycle erase clears every programmed mark, every row accumulator and err.
- R10: With enable clear, a data access is acknowledged in the next cycle, returns 0 and gives no pulse. The address still advances.
- R11: err stays set until an erase. It is visible both on the err port and in control bit 7.
- R12: Strobes that arrive while io_wait is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | One-cycle register read strobe |
| io_wr | input | 1 | One-cycle register write strobe (wins over io_rd) |
| io_sel | input | 3 | Register select |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with io_ack |
| io_ack | output | 1 | Access complete pulse |
| io_wait | output | 1 | Bus stall while a read or program is in progress |
| erase | input | 1 | Erase notification, clears integrity state |
| err | output | 1 | Sticky integrity violation flag |
| fl_addr | output | AW | Flash byte address {page,row,col} |
| fl_rdata | input | 8 | Flash array read data |
| fl_wdata | output | 8 | Byte being programmed |
| fl_prog | output | 1 | Program pulse active |

## Verification
Data writes are tried against fresh bytes, against bytes that have already been programmed, and against rows whose budget is nearly used up. These three cases separate an accepted pulse from the two kinds of refusal. Reads are run with wait-state counts of 0, 3 and 7, which exposes any miscount in the stall length. Addresses placed at the column and row ends show whether the carry into the row and page is right. A long random mix of addresses, pulse lengths, wait states, enable changes and erases is then checked against a bench model of the array and of the integrity bookkeeping.

// File: rtl/flash_io_pkg.sv
package flash_io_pkg;

    typedef enum logic [2:0] {
        RSEL_CTRL  = 3'd0,
        RSEL_PAGE  = 3'd1,
        RSEL_ROW   = 3'd2,
        RSEL_COL   = 3'd3,
        RSEL_DATA  = 3'd4,
        RSEL_PTIME = 3'd5
    } rsel_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_READ = 2'd1,
        SQ_PROG = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic       en;
        logic [2:0] ws;
    } ctrl_t;

    function automatic logic [7:0] clamp_len(input logic [7:0] v,
                                             input logic [7:0] lo,
                                             input logic [7:0] hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/fio_regs.sv
module fio_regs
    import flash_io_pkg::*;
#(
    parameter int PAGE_W   = 1,
    parameter int ROW_W    = 2,
    parameter int COL_W    = 8,
    parameter int PROG_MIN = 16,
    parameter int PROG_MAX = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  rsel_e             sel,
    input  logic [7:0]        wdata,
    input  logic              adv,
    input  logic              viol,
    input  logic              erase,
    output logic [PAGE_W-1:0] page,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output ctrl_t             ctrl,
    output logic [7:0]        len,
    output logic              err,
    output logic [7:0]        rd_val
);
    localparam logic [7:0] LEN_LO = 8'(PROG_MIN);
    localparam logic [7:0] LEN_HI = 8'(PROG_MAX);

    logic [7:0] ptime;

    always_ff @(posedge clk) begin
        if (rst) begin
            page  <= '0;
            row   <= '0;
            col   <= '0;
            ctrl  <= '0;
            ptime <= LEN_LO;
            err   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (sel)
                    RSEL_CTRL:  ctrl  <= '{en: wdata[0], ws: wdata[3:1]};
                    RSEL_PAGE:  page  <= wdata[PAGE_W-1:0];
                    RSEL_ROW:   row   <= wdata[ROW_W-1:0];
                    RSEL_COL:   col   <= wdata[COL_W-1:0];
                    RSEL_PTIME: ptime <= wdata;
                    default: ;
                endcase
            end
            if (adv) begin
                col <= col + 1'b1;
                if (&col) begin
                    row <= row + 1'b1;
                    if (&row) page <= page + 1'b1;
                end
            end
            if (erase)     err <= 1'b0;
            else if (viol) err <= 1'b1;
        end
    end

    assign len = clamp_len(ptime, LEN_LO, LEN_HI);

    always_comb begin
        case (sel)
            RSEL_CTRL:  rd_val = {err, 3'b000, ctrl.ws, ctrl.en};
            RSEL_PAGE:  rd_val = 8'(page);
            RSEL_ROW:   rd_val = 8'(row);
            RSEL_COL:   rd_val = 8'(col);
            RSEL_PTIME: rd_val = ptime;
            default:    rd_val = 8'h00;
        endcase
    end

endmodule

// File: rtl/fio_guard.sv
module fio_guard #(
    parameter int AW         = 11,
    parameter int RI_W       = 3,
    parameter int ROW_BUDGET = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            erase,
    input  logic [AW-1:0]   byte_idx,
    input  logic [RI_W-1:0] row_idx,
    input  logic [7:0]      len,
    input  logic            commit,
    output logic            byte_free,
    output logic            budget_ok
);
    localparam int NB    = 1 << AW;
    localparam int NR    = 1 << RI_W;
    localparam int ACC_W = $clog2(ROW_BUDGET + 256) + 1;

    logic [NB-1:0]    done;
    logic [ACC_W-1:0] acc [NR];
    logic [ACC_W-1:0] acc_sel;

    always_ff @(posedge clk) begin
        if (rst || erase) done <= '0;
        else if (commit)  done[byte_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (rst || erase)
                acc[i] <= '0;
            else if (commit && row_idx == RI_W'(i))
                acc[i] <= acc[i] + ACC_W'(len);
        end
    end

    assign acc_sel   = acc[row_idx];
    assign byte_free = !done[byte_idx];
    assign budget_ok = (acc_sel + ACC_W'(len)) <= ACC_W'(ROW_BUDGET);

endmodule

// File: rtl/fio_seq.sv
module fio_seq
    import flash_io_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_rd,
    input  logic       req_wr,
    input  logic       sel_data,
    input  ctrl_t      ctrl,
    input  logic [7:0] len,
    input  logic       byte_free,
    input  logic       budget_ok,
    input  logic [7:0] fl_rdata,
    input  logic [7:0] reg_rdata,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       ack,
    output logic [7:0] rdata,
    output logic       adv,
    output logic       commit,
    output logic       viol,
    output logic       reg_wr,
    output logic       prog,
    output logic [7:0] pdata
);
    sq_state_e  state;
    logic [7:0] cnt;
    logic       accept, data_wr, done_now;

    assign accept   = (req_rd || req_wr) && (state == SQ_IDLE);
    assign data_wr  = accept && req_wr && sel_data && ctrl.en;
    assign commit   = data_wr && byte_free && budget_ok;
    assign viol     = data_wr && !(byte_free && budget_ok);
    assign reg_wr   = accept && req_wr && !sel_data;
    assign done_now = (state != SQ_IDLE) && (cnt == 8'd0);
    assign adv      = (accept && sel_data && !ctrl.en) || viol || done_now;
    assign busy     = (state != SQ_IDLE);
    assign prog     = (state == SQ_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            ack   <= 1'b0;
            rdata <= '0;
            pdata <= '0;
        end else begin
            ack <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        if (!sel_data) begin
                            ack   <= 1'b1;
                            rdata <= req_wr ? 8'h00 : reg_rdata;
                        end else if (!ctrl.en || viol) begin
                            ack   <= 1'b1;
                            rdata <= 8'h00;
                        end else if (commit) begin
                            state <= SQ_PROG;
                            cnt   <= len - 8'd1;
                            pdata <= wdata;
                        end else begin
                            state <= SQ_READ;
                            cnt   <= 8'(ctrl.ws);
                        end
                    end
                end
                SQ_READ: begin
                    if (cnt == 8'd0) begin
                        state <= SQ_IDLE;
                        ack   <= 1'b1;
                        rdata <= fl_rdata;
                    end else begin
                        cnt <= cnt - 8'd1;
                    end
                end
                SQ_PROG: begin
                    if (cnt == 8'd0) begin
                        state <= SQ_IDLE;
                        ack   <= 1'b1;
                        rdata <= 8'h00;
                    end else begin
                        cnt <= cnt - 8'd1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_io_ctrl.sv
module flash_io_ctrl
    import flash_io_pkg::*;
#(
    parameter int PAGE_W     = 1,
    parameter int ROW_W      = 2,
    parameter int COL_W      = 8,
    parameter int PROG_MIN   = 16,
    parameter int PROG_MAX   = 24,
    parameter int ROW_BUDGET = 100,
    localparam int AW        = PAGE_W + ROW_W + COL_W,
    localparam int RI_W      = PAGE_W + ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic [2:0]    io_sel,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    output logic          io_ack,
    output logic          io_wait,
    input  logic          erase,
    output logic          err,
    output logic [AW-1:0] fl_addr,
    input  logic [7:0]    fl_rdata,
    output logic [7:0]    fl_wdata,
    output logic          fl_prog
);
    rsel_e             sel;
    ctrl_t             ctrl;
    logic [PAGE_W-1:0] page;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [7:0]        len, reg_rdata;
    logic              adv, viol, commit, reg_wr, byte_free, budget_ok;

    assign sel     = rsel_e'(io_sel);
    assign fl_addr = {page, row, col};

    fio_regs #(
        .PAGE_W(PAGE_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .PROG_MIN(PROG_MIN), .PROG_MAX(PROG_MAX)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(sel), .wdata(io_wdata),
        .adv(adv), .viol(viol), .erase(erase),
        .page(page), .row(row), .col(col), .ctrl(ctrl), .len(len),
        .err(err), .rd_val(reg_rdata)
    );

    fio_guard #(
        .AW(AW), .RI_W(RI_W), .ROW_BUDGET(ROW_BUDGET)
    ) u_guard (
        .clk(clk), .rst(rst), .erase(erase),
        .byte_idx(fl_addr), .row_idx({page, row}), .len(len), .commit(commit),
        .byte_free(byte_free), .budget_ok(budget_ok)
    );

    fio_seq u_seq (
        .clk(clk), .rst(rst), .req_rd(io_rd), .req_wr(io_wr),
        .sel_data(sel == RSEL_DATA), .ctrl(ctrl), .len(len),
        .byte_free(byte_free), .budget_ok(budget_ok),
        .fl_rdata(fl_rdata), .reg_rdata(reg_rdata), .wdata(io_wdata),
        .busy(io_wait), .ack(io_ack), .rdata(io_rdata), .adv(adv),
        .commit(commit), .viol(viol), .reg_wr(reg_wr), .prog(fl_prog),
        .pdata(fl_wdata)
    );

endmodule

// File: rtl/fio_checker.sv
module fio_checker #(
    parameter int AW       = 11,
    parameter int PROG_MAX = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          io_wait,
    input logic          io_ack,
    input logic          erase,
    input logic          err,
    input logic          fl_prog,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_wdata
);
    int unsigned run;

    always_ff @(posedge clk) begin
        if (rst)          run <= 0;
        else if (fl_prog) run <= run + 1;
        else              run <= 0;
    end

    p_prog_stalls_r5: assert property (@(posedge clk) disable iff (rst)
        fl_prog |-> io_wait);

    p_prog_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (fl_prog && $past(fl_prog)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    p_prog_bound_r6: assert property (@(posedge clk) disable iff (rst)
        fl_prog |-> (run < PROG_MAX));

    p_ack_free_r3: assert property (@(posedge clk) disable iff (rst)
        io_ack |-> !io_wait);

    p_wait_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(io_wait) |-> io_ack);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (err && !erase) |=> err);

    p_erase_clears_r9: assert property (@(posedge clk) disable iff (rst)
        erase |=> !err);

endmodule

bind flash_io_ctrl fio_checker #(.AW(AW), .PROG_MAX(PROG_MAX)) u_chk (
    .clk(clk), .rst(rst), .io_wait(io_wait), .io_ack(io_ack),
    .erase(erase), .err(err), .fl_prog(fl_prog),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata)
);

// File: tb/sim_flash_io_ctrl.sv
module sim_flash_io_ctrl;
    localparam int AW     = 11;
    localparam int NB     = 1 << AW;
    localparam int NR     = 8;
    localparam int PMIN   = 16;
    localparam int PMAX   = 24;
    localparam int BUDGET = 100;
    localparam logic [2:0] S_CTRL = 3'd0, S_PAGE = 3'd1, S_ROW = 3'd2,
                           S_COL = 3'd3, S_DATA = 3'd4, S_PT = 3'd5;

    logic clk = 1'b0, rst = 1'b1;
    logic io_rd = 0, io_wr = 0, erase = 0;
    logic [2:0] io_sel = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata, fl_rdata, fl_wdata;
    logic io_ack, io_wait, err, fl_prog;
    logic [AW-1:0] fl_addr;

    always #4 clk = ~clk;

    flash_io_ctrl u0 (
        .clk(clk), .rst(rst), .io_rd(io_rd), .io_wr(io_wr), .io_sel(io_sel),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
        .io_wait(io_wait), .erase(erase), .err(err), .fl_addr(fl_addr),
        .fl_rdata(fl_rdata), .fl_wdata(fl_wdata), .fl_prog(fl_prog)
    );

    logic [7:0] flash [NB];
    assign fl_rdata = flash[fl_addr];
    always @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < NB; i++) flash[i] <= 8'hFF;
        end else if (fl_prog) begin
            flash[fl_addr] <= flash[fl_addr] & fl_wdata;
        end
    end

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] exp_mem [NB];
    bit exp_done [NB];
    int exp_acc [NR];
    int exp_addr = 0, exp_ws = 0, exp_pt = PMIN;
    bit exp_en = 0, exp_err = 0;

    function automatic int f_len(input int v);
        if (v < PMIN) return PMIN;
        if (v > PMAX) return PMAX;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [2:0] sel, input logic [7:0] d,
                          output logic [7:0] rd, output int lat, output int wcnt,
                          output int pcnt);
        @(negedge clk);
        io_rd = !wr; io_wr = wr; io_sel = sel; io_wdata = d;
        lat = 0; wcnt = 0; pcnt = 0; rd = '0;
        forever begin
            @(negedge clk);
            io_rd = 0; io_wr = 0;
            lat++;
            if (io_wait) wcnt++;
            if (fl_prog) pcnt++;
            if (io_ack) begin
                rd = io_rdata;
                break;
            end
            if (lat > 1000) begin
                chk(0, "watchdog-access", lat, 0);
                break;
            end
        end
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [7:0] d);
        logic [7:0] r; int l, w, p;
        access(1, sel, d, r, l, w, p);
    endtask

    task automatic rreg(input logic [2:0] sel, output logic [7:0] v);
        int l, w, p;
        access(0, sel, 8'h00, v, l, w, p);
    endtask

    task automatic set_addr(input int a);
        wreg(S_PAGE, 8'(a >> 10));
        wreg(S_ROW, 8'((a >> 8) & 3));
        wreg(S_COL, 8'(a & 255));
        exp_addr = a;
    endtask

    task automatic set_ctrl(input bit en, input int ws);
        wreg(S_CTRL, {4'b0, 3'(ws), en});
        exp_en = en; exp_ws = ws;
    endtask

    task automatic set_pt(input int v);
        wreg(S_PT, 8'(v));
        exp_pt = v;
    endtask

    task automatic do_erase();
        @(negedge clk); erase = 1;
        @(negedge clk); erase = 0;
        for (int i = 0; i < NB; i++) begin exp_mem[i] = 8'hFF; exp_done[i] = 0; end
        for (int i = 0; i < NR; i++) exp_acc[i] = 0;
        exp_err = 0;
    endtask

    task automatic data_write(input logic [7:0] d, input string req);
        logic [7:0] r; int l, w, p, len, a, ri; bit ok;
        a = exp_addr; ri = a >> 8; len = f_len(exp_pt);
        access(1, S_DATA, d, r, l, w, p);
        if (!exp_en) begin
            chk(l == 1 && p == 0, {req, " R10 disabled write"}, l * 100 + p, 100);
        end else begin
            ok = !exp_done[a] && (exp_acc[ri] + len <= BUDGET);
            if (ok) begin
                chk(p == len && w == len, {req, " R5 pulse length"}, p, len);
                chk(l == len + 1, {req, " R5 ack latency"}, l, len + 1);
                exp_mem[a] = exp_mem[a] & d; exp_done[a] = 1; exp_acc[ri] += len;
            end else begin
                chk(l == 1 && p == 0, {req, " R7/R8 refused write"}, l * 100 + p, 100);
                exp_err = 1;
            end
        end
        exp_addr = (a + 1) % NB;
    endtask

    task automatic data_read(input string req);
        logic [7:0] r; int l, w, p, a, ev, el, ew;
        a = exp_addr;
        ev = exp_en ? int'(exp_mem[a]) : 0;
        el = exp_en ? exp_ws + 2 : 1;
        ew = exp_en ? exp_ws + 1 : 0;
        access(0, S_DATA, 8'h00, r, l, w, p);
        chk(int'(r) == ev, {req, " R3 read data"}, r, ev);
        chk(l == el && w == ew, {req, " R3 read timing"}, l * 100 + w, el * 100 + ew);
        exp_addr = (a + 1) % NB;
    endtask

    task automatic check_addr(input string req);
        logic [7:0] pg, rw, cl; int got;
        rreg(S_PAGE, pg); rreg(S_ROW, rw); rreg(S_COL, cl);
        got = int'(pg) * 1024 + int'(rw) * 256 + int'(cl);
        chk(got == exp_addr, {req, " R4 address"}, got, exp_addr);
    endtask

    task automatic check_err(input string req);
        logic [7:0] c;
        rreg(S_CTRL, c);
        chk(c[7] == exp_err && err == exp_err, {req, " R11 error flag"}, {c[7], err}, {exp_err, exp_err});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v; logic [7:0] r; int l, w, p, a, len;
        for (int i = 0; i < NB; i++) begin flash[i] = 8'hFF; exp_mem[i] = 8'hFF; exp_done[i] = 0; end
        for (int i = 0; i < NR; i++) exp_acc[i] = 0;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk(!io_wait && !io_ack && !fl_prog && !err, "R1 outputs idle", {io_wait, io_ack, fl_prog, err}, 0);
        rreg(S_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
        rreg(S_PT, v);   chk(v == PMIN, "R1 pulse length", v, PMIN);
        check_addr("R1");

        // R2 register readback and timing
        access(1, S_COL, 8'hAB, r, l, w, p);
        chk(l == 1 && w == 0, "R2 register write timing", l * 100 + w, 100);
        wreg(S_PAGE, 8'h01); wreg(S_ROW, 8'h03);
        rreg(S_COL, v);  chk(v == 8'hAB, "R2 column readback", v, 8'hAB);
        rreg(S_ROW, v);  chk(v == 8'h03, "R2 row readback", v, 3);
        rreg(S_PAGE, v); chk(v == 8'h01, "R2 page readback", v, 1);
        exp_addr = 1024 + 768 + 171;

        // R10 disabled access
        data_write(8'h00, "R10");
        check_addr("R10");
        data_read("R10");
        chk(flash[1024 + 768 + 171] == 8'hFF, "R10 no programming", flash[1024 + 768 + 171], 255);

        // R5 program and R3 reads with several wait states
        set_ctrl(1, 0);
        set_addr(40);
        data_write(8'h5A, "R5");
        foreach (exp_mem[i]) if (exp_mem[i] != flash[i]) begin chk(0, "R5 array", flash[i], exp_mem[i]); break; end
        set_addr(40); data_read("R3 ws0");
        set_ctrl(1, 3); set_addr(40); data_read("R3 ws3");
        set_ctrl(1, 7); set_addr(40); data_read("R3 ws7");
        set_ctrl(1, 0);

        // R4 column and row carries
        set_addr(255);  data_read("R4 col wrap"); check_addr("R4 col wrap");
        set_addr(1023); data_read("R4 row wrap"); check_addr("R4 row wrap");
        set_addr(2047); data_read("R4 page wrap"); check_addr("R4 page wrap");

        // R6 clamping
        set_pt(2);   rreg(S_PT, v); chk(v == 2, "R6 raw readback", v, 2);
        set_addr(100); data_write(8'h0F, "R6 low clamp");
        set_pt(200); set_addr(101); data_write(8'hF0, "R6 high clamp");
        set_pt(20);  set_addr(102); data_write(8'h33, "R6 in range");

        // R7 double program
        set_addr(300); data_write(8'h77, "R7 first");
        check_err("R7 before");
        set_addr(300); data_write(8'h00, "R7 second");
        check_addr("R7 advance");
        set_addr(300); data_read("R7 unchanged");
        check_err("R7 after");
        set_addr(310); data_write(8'h12, "R11 good op");
        check_err("R11 still set");

        // R9 erase
        do_erase();
        check_err("R9 erase clears");
        set_addr(300); data_write(8'h11, "R9 reprogram");
        set_addr(300); data_read("R9 reprogram read");

        // R8 row budget
        do_erase(); set_pt(20);
        for (int k = 0; k < 6; k++) begin
            set_addr(1280 + k * 7);
            data_write(8'(k), "R8 budget");
        end
        check_err("R8 budget refusal");

        // R12 strobes during wait ignored
        do_erase(); set_pt(16); set_addr(500);
        @(negedge clk); io_wr = 1; io_sel = S_DATA; io_wdata = 8'hC3;
        @(negedge clk); io_wr = 0;
        @(negedge clk); io_wr = 1; io_sel = S_COL; io_wdata = 8'h55;
        @(negedge clk); io_wr = 0;
        l = 0;
        while (!io_ack && l < 100) begin @(negedge clk); l++; end
        exp_mem[500] = 8'hC3; exp_done[500] = 1; exp_acc[1] += 16; exp_addr = 501;
        check_addr("R12 stalled strobe");

        // random phase
        for (int n = 0; n < 250; n++) begin
            if (n % 40 == 39) do_erase();
            if ($urandom % 10 == 0) set_ctrl($urandom % 8 != 0, $urandom % 8);
            if ($urandom % 8 == 0) set_pt($urandom % 40);
            a = $urandom % NB;
            if ($urandom % 4 == 0) a = (a & ~255) | 255;
            set_addr(a);
            if ($urandom % 2) data_write(8'($urandom), "random R5/R7/R8");
            else data_read("random R3");
            if ($urandom % 5 == 0) check_addr("random");
            if (n % 25 == 0) check_err("random");
        end
        set_ctrl(1, 0);
        for (int i = 0; i < 64; i++) begin
            set_addr(i * 32); data_read("final R5 array");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule